// File: doc/BRIEF.md
# Shared Bus Contention Resolver

This block takes N candidate drivers of one shared address/data bus. Each driver has an enable bit, an address word and a data word. Once per clock cycle the block merges them into one resolved bus value. It counts how many drivers are enabled. With exactly one enabled, the output carries that driver's address and data. With none enabled, the block raises an idle flag. With two or more enabled, it raises a conflict flag and shows a reserved contention code.

A mode input decides what the output shows while the bus is undriven. In default mode it shows a reserved undriven code. In hold mode it keeps the last resolved value. All outputs are registered. A saturating counter records how many cycles have seen contention. Scanning order has no effect on the result, because the merge is a masked OR over all lanes and the count is a population count.

Top module: `bus_resolver`

## Requirements
- R1: A synchronous active-high reset `rst` sets res_addr and res_data to all-ones, clears `idle` and `conflict`, and clears `conflict_cnt` to 0.
- R2: When exactly one bit of `drv_en` is set, the address and data of that driver (lane i occupies bits i*W +: W of the flat buses) appear unchanged on res_addr/res_data, with idle=0 and conflict=0.
- R3: When no bit of `drv_en` is set and `hold_mode`=0, res_addr and res_data both become all-ones (the -1 pattern) and idle=1, conflict=0.
- R4: When no bit of `drv_en` is set and `hold_mode`=1, res_addr and res_data keep their previous resolved value, whatever it was, and idle=1, conflict=0.
- R5: When two or more bits of `drv_en` are set, res_addr and res_data both become the -2 pattern (all ones except bit 0 = 0) and conflict=1, idle=0.
- R6: The address and data of a driver whose enable bit is 0 have no effect on any output.
- R7: `idle` is 1 exactly when no driver was enabled in the previous cycle, in either mode, and `idle` and `conflict` are never 1 together.
- R8: `conflict_cnt` (8 bits) goes up by one at each clock edge whose cycle has two or more drivers enabled.
- R9: `conflict_cnt` saturates at 255 and stays there while contention goes on.
- R10: Every output changes only at a rising clock edge and reflects the inputs sampled at that edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_mode | input | 1 | 1: keep last value while undriven; 0: show undriven code |
| drv_en | input | N_DRV | Per-driver enable |
| drv_addr | input | N_DRV*ADDR_W | Driver addresses, lane i at bits i*ADDR_W +: ADDR_W |
| drv_data | input | N_DRV*DATA_W | Driver data, lane i at bits i*DATA_W +: DATA_W |
| res_addr | output | ADDR_W | Resolved address |
| res_data | output | DATA_W | Resolved data |
| idle | output | 1 | No driver was enabled |
| conflict | output | 1 | Two or more drivers were enabled |
| conflict_cnt | output | CNT_W | Saturating count of contention cycles |

## Verification
Two functions can take effect at the same edge: the switch to the contention code and the step of the saturating counter. Hold mode can also meet a contention code that was just produced. The vector table puts contention cycles directly before and after undriven cycles in hold mode. The bench then checks that the held word is the -2 pattern and that the counter stepped only on contention cycles. A long contention burst drives the counter to its ceiling, and one further contention cycle must leave it at 255.

// File: rtl/bres_pkg.sv
`timescale 1ns/1ps
package bres_pkg;

  typedef enum logic [1:0] {
    RK_IDLE  = 2'd0,
    RK_ONE   = 2'd1,
    RK_MULTI = 2'd2
  } res_kind_e;

  // Map an active-driver count onto its resolution class.
  function automatic res_kind_e classify(input int unsigned n);
    if (n == 0)      return RK_IDLE;
    else if (n == 1) return RK_ONE;
    else             return RK_MULTI;
  endfunction

endpackage

// File: rtl/bres_tally.sv
`timescale 1ns/1ps
module bres_tally
  import bres_pkg::*;
#(
  parameter int N_DRV = 4,
  localparam int CW = $clog2(N_DRV + 1)
) (
  input  logic [N_DRV-1:0] en,
  output logic [CW-1:0]    active_cnt,
  output res_kind_e        kind
);

  // Population count: order independent by construction of a sum.
  function automatic logic [CW-1:0] popcnt(input logic [N_DRV-1:0] v);
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N_DRV; i++) acc = acc + CW'(v[i]);
    return acc;
  endfunction

  assign active_cnt = popcnt(en);
  assign kind       = classify(int'(active_cnt));

  // R2 / R5: class decision agrees with an independent bit count
  always_comb begin
    a_single_class_r2: assert ((kind == RK_ONE) == ($countones(en) == 1));
    a_multi_class_r5:  assert ((kind == RK_MULTI) == ($countones(en) > 1));
  end

endmodule

// File: rtl/bres_merge.sv
`timescale 1ns/1ps
module bres_merge #(
  parameter int N_DRV = 4,
  parameter int W     = 32
) (
  input  logic [N_DRV-1:0]   en,
  input  logic [N_DRV*W-1:0] words,
  output logic [W-1:0]       merged
);

  logic [W-1:0] lane_masked [N_DRV];

  // A disabled lane contributes zero to the OR, the neutral element.
  for (genvar g = 0; g < N_DRV; g++) begin : g_lane
    assign lane_masked[g] = words[g*W +: W] & {W{en[g]}};
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < N_DRV; i++) merged = merged | lane_masked[i];
  end

  // R6: with nothing enabled the merge is empty regardless of the words
  always_comb begin
    a_masked_empty_r6: assert ((en != '0) || (merged == '0));
  end

endmodule

// File: rtl/bres_sat_cnt.sv
`timescale 1ns/1ps
module bres_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CMAX = '1;

  wire at_max = (cnt == CMAX);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (inc && !at_max) cnt <= cnt + 1'b1;
  end

  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    (inc && !at_max) |=> (cnt == $past(cnt) + 1'b1));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    at_max |=> (cnt == CMAX));

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));

endmodule

// File: rtl/bus_resolver.sv
`timescale 1ns/1ps
module bus_resolver
  import bres_pkg::*;
#(
  parameter int N_DRV  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hold_mode,
  input  logic [N_DRV-1:0]         drv_en,
  input  logic [N_DRV*ADDR_W-1:0]  drv_addr,
  input  logic [N_DRV*DATA_W-1:0]  drv_data,
  output logic [ADDR_W-1:0]        res_addr,
  output logic [DATA_W-1:0]        res_data,
  output logic                     idle,
  output logic                     conflict,
  output logic [CNT_W-1:0]         conflict_cnt
);

  localparam int WW = ADDR_W + DATA_W;
  localparam int CW = $clog2(N_DRV + 1);
  localparam logic [ADDR_W-1:0] UNDRV_A = '1;
  localparam logic [DATA_W-1:0] UNDRV_D = '1;
  localparam logic [ADDR_W-1:0] MULTI_A = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [DATA_W-1:0] MULTI_D = {{(DATA_W-1){1'b1}}, 1'b0};

  // Per-lane packing of address over data.
  logic [N_DRV*WW-1:0] lane_words;
  for (genvar g = 0; g < N_DRV; g++) begin : g_pack
    assign lane_words[g*WW +: WW] = {drv_addr[g*ADDR_W +: ADDR_W],
                                     drv_data[g*DATA_W +: DATA_W]};
  end

  logic [CW-1:0] active_cnt;
  res_kind_e     kind;
  logic [WW-1:0] merged;

  bres_tally #(.N_DRV(N_DRV)) u_tally (
    .en         (drv_en),
    .active_cnt (active_cnt),
    .kind       (kind)
  );

  bres_merge #(.N_DRV(N_DRV), .W(WW)) u_merge (
    .en     (drv_en),
    .words  (lane_words),
    .merged (merged)
  );

  // Named events for the assertions.
  wire none_w   = (kind == RK_IDLE);
  wire single_w = (kind == RK_ONE);
  wire multi_w  = (kind == RK_MULTI);

  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] nxt_data;

  always_comb begin
    unique case (kind)
      RK_ONE:   {nxt_addr, nxt_data} = merged;
      RK_MULTI: {nxt_addr, nxt_data} = {MULTI_A, MULTI_D};
      default:  {nxt_addr, nxt_data} = hold_mode ? {res_addr, res_data}
                                                 : {UNDRV_A, UNDRV_D};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_addr <= UNDRV_A;
      res_data <= UNDRV_D;
      idle     <= 1'b0;
      conflict <= 1'b0;
    end else begin
      res_addr <= nxt_addr;
      res_data <= nxt_data;
      idle     <= none_w;
      conflict <= multi_w;
    end
  end

  bres_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .inc (multi_w),
    .cnt (conflict_cnt)
  );

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(idle && conflict));

  p_idle_flag_r7: assert property (@(posedge clk) disable iff (rst)
    none_w |=> idle);

  p_conflict_code_r5: assert property (@(posedge clk) disable iff (rst)
    multi_w |=> (conflict && res_addr == MULTI_A && res_data == MULTI_D));

  p_undriven_code_r3: assert property (@(posedge clk) disable iff (rst)
    (none_w && !hold_mode) |=> (res_addr == UNDRV_A && res_data == UNDRV_D));

  p_hold_value_r4: assert property (@(posedge clk) disable iff (rst)
    (none_w && hold_mode) |=> ($stable(res_addr) && $stable(res_data)));

  p_single_clear_r2: assert property (@(posedge clk) disable iff (rst)
    single_w |=> (!idle && !conflict));

endmodule

// File: tb/bus_resolver_test.sv
`timescale 1ns/1ps
module bus_resolver_test;

  localparam int N = 4;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_mode = 1'b0;
  logic [N-1:0] drv_en = '0;
  logic [N*AW-1:0] drv_addr = '0;
  logic [N*DW-1:0] drv_data = '0;
  logic [AW-1:0] res_addr;
  logic [DW-1:0] res_data;
  logic idle, conflict;
  logic [7:0] conflict_cnt;

  always #4 clk = ~clk;

  bus_resolver uut (
    .clk(clk), .rst(rst), .hold_mode(hold_mode), .drv_en(drv_en),
    .drv_addr(drv_addr), .drv_data(drv_data), .res_addr(res_addr),
    .res_data(res_data), .idle(idle), .conflict(conflict),
    .conflict_cnt(conflict_cnt)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] a_of(input int i, input int s);
    return AW'(16'hA000 + i * 16'h0111 + s);
  endfunction
  function automatic logic [DW-1:0] d_of(input int i, input int s);
    return DW'(16'h5A00 ^ (i << 9) ^ (s * 7));
  endfunction

  task automatic load(input int s);
    for (int i = 0; i < N; i++) begin
      drv_addr[i*AW +: AW] = a_of(i, s);
      drv_data[i*DW +: DW] = d_of(i, s);
    end
  endtask

  // {hold_mode, drv_en}
  localparam int NV = 16;
  localparam logic [4:0] VEC [NV] = '{
    5'b0_0001, 5'b0_0100, 5'b0_0000, 5'b0_1000,
    5'b1_0000, 5'b1_0000, 5'b0_0110, 5'b1_0000,
    5'b0_1111, 5'b0_0000, 5'b1_0010, 5'b1_0000,
    5'b0_1001, 5'b1_1110, 5'b0_0010, 5'b1_0000
  };

  logic [31:0] model_word;
  logic [7:0]  model_cnt;

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    string tag;
    logic mi, mc;
    int s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset", {res_addr, res_data, idle, conflict, conflict_cnt},
        {32'hFFFF_FFFF, 1'b0, 1'b0, 8'd0});
    model_word = 32'hFFFF_FFFF;
    model_cnt = 0;

    // Table walk (R2 R3 R4 R5 R7 R8)
    for (int k = 0; k < NV; k++) begin
      int cnt1;
      int pick;
      s0 = k * 19;
      hold_mode = VEC[k][4];
      drv_en = VEC[k][3:0];
      load(s0);
      cnt1 = 0; pick = 0;
      for (int i = 0; i < N; i++) if (drv_en[i]) begin cnt1++; pick = i; end
      if (cnt1 == 1) begin
        model_word = {a_of(pick, s0), d_of(pick, s0)}; mi = 0; mc = 0; tag = "R2 single";
      end else if (cnt1 == 0) begin
        mi = 1; mc = 0;
        if (hold_mode) tag = "R4 hold";
        else begin model_word = 32'hFFFF_FFFF; tag = "R3 undriven"; end
      end else begin
        model_word = 32'hFFFE_FFFE; mi = 0; mc = 1; tag = "R5 contention";
        if (model_cnt != 8'hFF) model_cnt++;
      end
      @(negedge clk);
      chk(tag, {res_addr, res_data, idle, conflict}, {model_word, mi, mc});
      chk("R8 count", conflict_cnt, model_cnt);
      chk("R7 flags exclusive", idle & conflict, 1'b0);
    end

    // R10: output unchanged before the edge, updated after it
    hold_mode = 0; drv_en = 4'b0100; load(200);
    #1;
    chk("R10 no early change", {res_addr, res_data}, model_word);
    @(negedge clk);
    chk("R10 one-cycle update", {res_addr, res_data}, {a_of(2, 200), d_of(2, 200)});

    // R6: disabled lanes changed while one lane stays enabled
    for (int i = 0; i < N; i++) if (i != 2) begin
      drv_addr[i*AW +: AW] = 16'h0F0F;
      drv_data[i*DW +: DW] = 16'hF0F0;
    end
    @(negedge clk);
    chk("R6 disabled lanes ignored", {res_addr, res_data}, {a_of(2, 200), d_of(2, 200)});
    drv_en = 4'b0000; load(77);
    @(negedge clk);
    chk("R6 idle ignores words", {res_addr, res_data, idle}, {32'hFFFF_FFFF, 1'b1});

    // R9: saturation under a long contention burst
    drv_en = 4'b0011;
    repeat (300) @(negedge clk);
    chk("R9 saturated", conflict_cnt, 8'hFF);
    @(negedge clk);
    chk("R9 stays saturated", conflict_cnt, 8'hFF);
    hold_mode = 1; drv_en = 4'b0000;
    @(negedge clk);
    chk("R4 holds contention code", {res_addr, res_data, idle, conflict},
        {32'hFFFE_FFFE, 1'b1, 1'b0});

    // R1: mid-run reset clears everything
    rst = 1'b1; drv_en = 4'b1100;
    @(negedge clk);
    chk("R1 mid-run reset", {res_addr, res_data, idle, conflict, conflict_cnt},
        {32'hFFFF_FFFF, 1'b0, 1'b0, 8'd0});
    rst = 1'b0; drv_en = 4'b0000;
    @(negedge clk);
    chk("R4 hold after reset", {res_addr, res_data, idle}, {32'hFFFF_FFFF, 1'b1});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule